// File: doc/BRIEF.md
# Exception Cause and Return-Address Capture

This block sits beside a multi-cycle processor datapath and its state-machine controller. It handles two kinds of exception: an undefined instruction and an arithmetic overflow. When the controller enters an exception state, the block saves the address of the faulting instruction in a 32-bit return-address register. It records a fixed cause code in a cause register. It also steers the next program counter to one fixed handler entry point, shared by both causes. The handler tells the causes apart by reading the cause register.

The program counter has already been advanced by one instruction (4 bytes) during fetch. The saved address is therefore the current counter minus 4.

The block also raises an overflow trap request while the controller is in the register-type execute state and the ALU flags an overflow. The controller uses this request to go to the overflow exception state instead of register write-back, so no register file write takes place. In that exception state the controller asserts both write enables in the same cycle and selects the handler input of the PC multiplexer. The return address, the cause and the counter are then all updated on one clock edge, and fetch follows.

Top module: `exc_capture`

## Requirements
- R1: While reset (`rst_n` low) is applied, and in the first cycle after it is released, `epc_q` and `cause_q` read zero.
- R2: When `epc_wr` is high at a rising clock edge, `epc_q` becomes `pc_plus4 - 4` (modulo 2^32). A counter value of 0 therefore gives 32'hFFFF_FFFC.
- R3: When `epc_wr` is low at a rising edge, `epc_q` keeps its value.
- R4: When `cause_wr` is high at a rising edge, `cause_q` becomes 32'd0 if `int_cause` is 0 (undefined instruction), or 32'd1 if `int_cause` is 1 (arithmetic overflow).
- R5: When `cause_wr` is low at a rising edge, `cause_q` keeps its value.
- R6: When `pc_sel` is 2'b11, `pc_next` equals the parameter `HANDLER_ADDR` (default 32'h8000_0180) in the same cycle, whatever the other data inputs are.
- R7: `pc_sel` 2'b00 passes `alu_result` to `pc_next`, 2'b01 passes `alu_hold`, and 2'b10 passes `jump_tgt`, with no clock delay.
- R8: `trap_ovf` is high exactly when `rtype_exec` and `alu_ovf` are both high. An overflow outside the register-type execute state raises no request.
- R9: With `epc_wr` and `cause_wr` both high at one edge, both registers take their new values on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| epc_wr | input | 1 | Return-address register write enable |
| cause_wr | input | 1 | Cause register write enable |
| int_cause | input | 1 | Cause select: 0 undefined instruction, 1 overflow |
| pc_plus4 | input | 32 | Current (already advanced) program counter |
| alu_ovf | input | 1 | ALU overflow flag |
| rtype_exec | input | 1 | Controller is in the register-type execute state |
| pc_sel | input | 2 | PC source select |
| alu_result | input | 32 | Live ALU output (sequential PC) |
| alu_hold | input | 32 | Held ALU result register (branch target) |
| jump_tgt | input | 32 | Assembled jump target |
| pc_next | output | 32 | Selected next program counter |
| epc_q | output | 32 | Saved faulting-instruction address |
| cause_q | output | 32 | Recorded cause code |
| trap_ovf | output | 1 | Overflow trap request to the controller |

## Verification
The bench first drives a fixed sequence of the two real exception scenarios. An undefined-instruction trap writes cause 0, and an overflow trap writes cause 1. Each trap writes both registers together with the handler selected, which separates a correct minus-4 return address from an unadjusted one. It also shows whether the cause code follows the select input. Later phases walk every PC source with distinct data words, so a swapped multiplexer leg shows up. Other phases toggle each write enable alone, to catch a register that updates when it should hold, and sweep the overflow/execute combinations to separate a correct AND from a plain pass-through of the flag. A counter value of zero checks the wrap of the return address.

// File: rtl/exc_capture_pkg.sv
package exc_capture_pkg;
  parameter int unsigned WORD_W = 32;
  localparam int unsigned INSN_BYTES = 4;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    PCS_SEQ    = 2'b00,
    PCS_BRANCH = 2'b01,
    PCS_JUMP   = 2'b10,
    PCS_TRAP   = 2'b11
  } pc_src_e;

  typedef enum logic {
    CAUSE_UNDEF = 1'b0,
    CAUSE_OVF   = 1'b1
  } cause_e;

  // address of the instruction that was fetched before the counter advanced
  function automatic word_t rewind_pc(input word_t advanced);
    return advanced - word_t'(INSN_BYTES);
  endfunction

  function automatic word_t cause_word(input cause_e c);
    return (c == CAUSE_OVF) ? word_t'(1) : word_t'(0);
  endfunction
endpackage

// File: rtl/exc_epc_reg.sv
module exc_epc_reg
  import exc_capture_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t pc_adv,
  output word_t epc
);
  word_t save_addr;
  assign save_addr = rewind_pc(pc_adv);

  always_ff @(posedge clk) begin
    if (!rst_n)  epc <= '0;
    else if (wr) epc <= save_addr;
  end

  assert_epc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> epc == $past(pc_adv) - word_t'(INSN_BYTES));
  assert_epc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(epc));
endmodule

// File: rtl/exc_cause_reg.sv
module exc_cause_reg
  import exc_capture_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  logic  sel,
  output word_t cause
);
  word_t code;
  assign code = cause_word(cause_e'(sel));

  always_ff @(posedge clk) begin
    if (!rst_n)  cause <= '0;
    else if (wr) cause <= code;
  end

  assert_cause_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> cause == {{(WORD_W-1){1'b0}}, $past(sel)});
  assert_cause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(cause));
  assert_cause_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cause[WORD_W-1:1] == '0);
endmodule

// File: rtl/exc_pc_mux.sv
module exc_pc_mux
  import exc_capture_pkg::*;
#(
  parameter word_t HANDLER_ADDR = 32'h8000_0180
) (
  input  logic [1:0] sel,
  input  word_t      seq_pc,
  input  word_t      branch_pc,
  input  word_t      jump_pc,
  output word_t      next_pc
);
  localparam int unsigned NLEGS = 4;
  word_t legs [NLEGS];

  assign legs[PCS_SEQ]    = seq_pc;
  assign legs[PCS_BRANCH] = branch_pc;
  assign legs[PCS_JUMP]   = jump_pc;
  assign legs[PCS_TRAP]   = HANDLER_ADDR;

  assign next_pc = legs[sel];
endmodule

// File: rtl/exc_capture.sv
module exc_capture
  import exc_capture_pkg::*;
#(
  parameter logic [31:0] HANDLER_ADDR = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        epc_wr,
  input  logic        cause_wr,
  input  logic        int_cause,
  input  logic [31:0] pc_plus4,
  input  logic        alu_ovf,
  input  logic        rtype_exec,
  input  logic [1:0]  pc_sel,
  input  logic [31:0] alu_result,
  input  logic [31:0] alu_hold,
  input  logic [31:0] jump_tgt,
  output logic [31:0] pc_next,
  output logic [31:0] epc_q,
  output logic [31:0] cause_q,
  output logic        trap_ovf
);
  // named event: both capture registers written on one edge
  logic joint_capture;
  assign joint_capture = epc_wr & cause_wr;

  assign trap_ovf = rtype_exec & alu_ovf;

  exc_epc_reg u_epc (
    .clk(clk), .rst_n(rst_n), .wr(epc_wr), .pc_adv(pc_plus4), .epc(epc_q)
  );

  exc_cause_reg u_cause (
    .clk(clk), .rst_n(rst_n), .wr(cause_wr), .sel(int_cause), .cause(cause_q)
  );

  exc_pc_mux #(.HANDLER_ADDR(HANDLER_ADDR)) u_mux (
    .sel(pc_sel), .seq_pc(alu_result), .branch_pc(alu_hold),
    .jump_pc(jump_tgt), .next_pc(pc_next)
  );

  assert_handler_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == 2'b11 |-> pc_next == HANDLER_ADDR);
  assert_seq_leg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pc_sel == 2'b00 |-> pc_next == alu_result);
  assert_trap_needs_exec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_ovf |-> (alu_ovf && rtype_exec));
  assert_joint_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    joint_capture |=> (epc_q == $past(pc_plus4) - 32'd4) &&
                      (cause_q == {31'b0, $past(int_cause)}));
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (epc_q == '0) && (cause_q == '0));
endmodule

// File: tb/exc_capture_bench.sv
module exc_capture_bench;
  localparam logic [31:0] HANDLER = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        epc_wr = 0, cause_wr = 0, int_cause = 0, alu_ovf = 0, rtype_exec = 0;
  logic [1:0]  pc_sel = 0;
  logic [31:0] pc_plus4 = 0, alu_result = 0, alu_hold = 0, jump_tgt = 0;
  logic [31:0] pc_next, epc_q, cause_q;
  logic        trap_ovf;

  int tests = 0;
  int fails = 0;
  logic [31:0] m_epc, m_cause;
  bit done = 0;

  always #4 clk = ~clk;

  exc_capture u_exc_capture (
    .clk(clk), .rst_n(rst_n), .epc_wr(epc_wr), .cause_wr(cause_wr),
    .int_cause(int_cause), .pc_plus4(pc_plus4), .alu_ovf(alu_ovf),
    .rtype_exec(rtype_exec), .pc_sel(pc_sel), .alu_result(alu_result),
    .alu_hold(alu_hold), .jump_tgt(jump_tgt), .pc_next(pc_next),
    .epc_q(epc_q), .cause_q(cause_q), .trap_ovf(trap_ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: apply inputs, check combinational outputs, step model, check registers
  task automatic cyc(input bit ew, input bit cw, input bit ic, input logic [31:0] pc,
                     input logic [1:0] sel, input bit ov, input bit rx);
    logic [31:0] exp_pc;
    epc_wr = ew; cause_wr = cw; int_cause = ic; pc_plus4 = pc; pc_sel = sel;
    alu_ovf = ov; rtype_exec = rx;
    alu_result = pc; alu_hold = pc ^ 32'h0F0F_0000; jump_tgt = {pc[31:28], 28'h0ABC_DE0};
    #1;
    case (sel)
      2'd0: exp_pc = alu_result;
      2'd1: exp_pc = alu_hold;
      2'd2: exp_pc = jump_tgt;
      default: exp_pc = HANDLER;
    endcase
    chk(sel == 2'd3 ? "R6 handler select" : "R7 pc source leg", pc_next, exp_pc);
    chk("R8 overflow trap request", {31'b0, trap_ovf}, {31'b0, (ov && rx)});
    if (ew) m_epc = pc - 32'd4;
    if (cw) m_cause = ic ? 32'd1 : 32'd0;
    @(posedge clk); @(negedge clk);
    chk(ew ? (cw ? "R9 joint epc" : "R2 epc load") : "R3 epc hold", epc_q, m_epc);
    chk(cw ? (ew ? "R9 joint cause" : "R4 cause load") : "R5 cause hold", cause_q, m_cause);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    m_epc = 0; m_cause = 0;
    @(negedge clk); @(negedge clk);
    chk("R1 epc in reset", epc_q, 32'h0);
    chk("R1 cause in reset", cause_q, 32'h0);
    rst_n = 1'b1;
    // undefined-instruction trap: handler selected, both written
    cyc(1, 1, 0, 32'h0040_0024, 2'd3, 0, 0);
    // normal sequential, branch, jump steps with holds
    cyc(0, 0, 1, 32'h0040_0028, 2'd0, 0, 0);
    cyc(0, 0, 0, 32'h1234_5678, 2'd1, 1, 0);
    cyc(0, 0, 1, 32'h9000_0010, 2'd2, 0, 1);
    // overflow in execute: request raised, then trap state
    cyc(0, 0, 0, 32'h0040_1000, 2'd0, 1, 1);
    cyc(1, 1, 1, 32'h0040_1000, 2'd3, 0, 0);
    // single-enable writes
    cyc(1, 0, 0, 32'hDEAD_BEE8, 2'd0, 0, 0);
    cyc(0, 1, 0, 32'h0000_0100, 2'd1, 0, 0);
    cyc(0, 1, 1, 32'h0000_0104, 2'd2, 0, 0);
    // wrap at zero
    cyc(1, 0, 0, 32'h0000_0000, 2'd3, 0, 0);
    // sweep overflow/execute combinations and all legs
    for (int i = 0; i < 16; i++)
      cyc(0, 0, 0, 32'h0100_0000 + 32'(i * 4), 2'(i), i[2], i[3]);
    rst_n = 1'b0;
    @(negedge clk);
    m_epc = 0; m_cause = 0;
    chk("R1 epc after reset", epc_q, 32'h0);
    chk("R1 cause after reset", cause_q, 32'h0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule